// File: doc/BRIEF.md
# Configurable UART Transmit Framer

This block turns one byte at a time into an asynchronous serial frame on a single output line. A host loads an 8-bit format register that selects how many data bits are sent (5 to 8), whether a parity bit follows and how it is formed, and how long the stop period lasts. The same register can force the line low to signal a break and can gate the baud tick that paces the frame. The host reads this register back unchanged.

Data enters through a one-entry holding buffer. When the serializer is free, it takes the byte from the buffer and raises an empty flag, so the host can queue the next byte while the current one is still being shifted out. Frames then follow each other with no idle gap. Each bit lasts a fixed number of baud ticks. The divisor that produces those ticks lives outside the block.

Top module: `uart_tx_framer`

## Requirements
- R1: After reset the line is high, the holding buffer reads empty and the format register reads 0x00.
- R2: A format-register write is read back unchanged on the next cycle. Bit 7 enables the baud tick, bit 6 forces a break, bit 5 selects stick parity, bit 4 selects even parity, bit 3 enables parity, bit 2 selects the long stop period, and bits 1:0 select the word length.
- R3: A frame is a low start bit, then the data bits least significant first, then optional parity, then a high stop period. Word-length codes 0, 1, 2 and 3 send 5, 6, 7 and 8 data bits, and every bit lasts 16 enabled ticks.
- R4: With parity enabled, the parity bit depends on the stick and even bits. Stick 0 / even 0 makes the count of ones in data plus parity odd. Stick 0 / even 1 makes that count even. Stick 1 / even 0 sends 1, and stick 1 / even 1 sends 0. With parity disabled, no parity bit is sent.
- R5: With the stop select bit clear, the stop period is 16 ticks. With it set, the stop period is 24 ticks at 5-bit words and 32 ticks at other word lengths.
- R6: A write to the holding buffer clears the empty flag on the next cycle. The flag rises when the serializer takes the byte, and a byte queued during a frame starts right after that frame's stop period.
- R7: While the break bit is set, the line reads 0. When the bit is cleared, the line returns to its frame or idle level.
- R8: While the baud enable bit is clear, the line does not change and a queued byte is not taken. Setting the bit starts the pending frame.
- R9: The word length, parity and stop settings are captured when a frame starts. A format write during a frame affects only later frames.
- R10: A buffer write in the same cycle that the serializer takes the previous byte leaves the flag low. The earlier byte is sent first and the new byte follows.

Top module ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lcr_wr | input | 1 | Format register write strobe |
| lcr_wdata | input | 8 | Format register write value |
| lcr_rdata | output | 8 | Format register contents |
| thr_wr | input | 1 | Holding buffer write strobe |
| thr_wdata | input | 8 | Byte to transmit |
| baud_tick | input | 1 | One-cycle baud pulse, 16 per bit |
| tx_out | output | 1 | Serial line |
| thr_empty | output | 1 | Holding buffer empty flag |

## Verification
Two events can land in the same clock cycle: the host writes the holding buffer, and the serializer takes the byte already waiting there. The bench provokes this with two writes on consecutive cycles while the line is idle and the tick runs every cycle. The second write then meets the load of the first byte. The bench judges the result in three ways: the empty flag must stay low, the first byte must appear on the line as the first frame, and the second byte must follow with exactly one frame length between the two start edges.

// File: rtl/uart_tx_pkg.sv
// Package: shared format-register type and helper functions for the
// transmit framer. Assumes an 8-bit data path and 16 ticks per bit.
package uart_tx_pkg;

    localparam int DATA_W  = 8;
    localparam int OVS     = 16;

    // Format register layout, most significant field first
    typedef struct packed {
        logic       brg_en;
        logic       brk;
        logic       stick;
        logic       even;
        logic       par_en;
        logic       stop_sel;
        logic [1:0] wls;
    } fmt_t;

    // Parity bit for the low (wls+5) bits of a byte under the given mode
    function automatic logic parity_bit(input logic [DATA_W-1:0] data,
                                        input logic [1:0]        wls,
                                        input logic              stick,
                                        input logic              even);
        logic ones;
        ones = 1'b0;
        for (int i = 0; i < DATA_W; i++) begin
            if (i < 5 + int'(wls)) ones = ones ^ data[i];
        end
        if (stick) return ~even;
        return even ? ones : ~ones;
    endfunction

endpackage

// File: rtl/uart_tx_ctrl_reg.sv
// Module: format register. Holds the host-written frame format and
// presents it unchanged for readback. Assumes a single write strobe.
module uart_tx_ctrl_reg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] q
);

    // Capture host writes, clear on reset
    always_ff @(posedge clk) begin
        if (!rst_n)  q <= '0;
        else if (wr) q <= wdata;
    end

endmodule

// File: rtl/uart_tx_holding.sv
// Module: one-entry holding buffer in front of the serializer.
// A write always wins over a same-cycle load: the load consumes the
// previously stored byte while the new byte takes its place.
module uart_tx_holding #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr,
    input  logic [DW-1:0] wdata,
    input  logic          load,
    output logic [DW-1:0] data,
    output logic          full
);

    // Track occupancy and store the queued byte
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            full <= 1'b0;
            data <= '0;
        end else if (wr) begin
            full <= 1'b1;
            data <= wdata;
        end else if (load) begin
            full <= 1'b0;
        end
    end

endmodule

// File: rtl/uart_tx_shifter.sv
// Module: frame serializer. Advances only on enabled ticks; latches the
// frame format when it takes a byte; chains frames with no idle gap.
// Assumes tick_en is a one-cycle pulse and OVS is even.
module uart_tx_shifter
    import uart_tx_pkg::*;
#(
    parameter int DW  = DATA_W,
    parameter int TPB = OVS
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick_en,
    input  logic          hold_full,
    input  logic [DW-1:0] hold_data,
    input  logic          par_en,
    input  logic          par_even,
    input  logic          par_stick,
    input  logic          stop_sel,
    input  logic [1:0]    wls,
    output logic          load,
    output logic          line
);

    localparam int CW = $clog2(2 * TPB);
    localparam int IW = $clog2(DW);
    localparam logic [CW-1:0] BIT_LAST   = CW'(TPB - 1);
    localparam logic [CW-1:0] STOP1_LAST = CW'(TPB - 1);
    localparam logic [CW-1:0] STOP15_LAST = CW'(TPB + TPB / 2 - 1);
    localparam logic [CW-1:0] STOP2_LAST = CW'(2 * TPB - 1);

    typedef enum logic [2:0] {S_IDLE, S_START, S_DATA, S_PAR, S_STOP} st_t;

    st_t            state;
    logic [CW-1:0]  cnt;
    logic [DW-1:0]  sh;
    logic [IW-1:0]  idx;
    logic [IW-1:0]  last_idx;
    logic           par_on;
    logic           par_val;
    logic [CW-1:0]  stop_last;
    logic           stop_done;
    logic           bit_done;
    logic [CW-1:0]  stop_last_new;

    // End-of-period detection for the current bit or stop period
    always_comb begin
        bit_done  = (cnt == BIT_LAST);
        stop_done = (state == S_STOP) && (cnt == stop_last);
        load = tick_en && hold_full && ((state == S_IDLE) || stop_done);
    end

    // Stop-period length from the live format at frame start
    always_comb begin
        if (!stop_sel)        stop_last_new = STOP1_LAST;
        else if (wls == 2'b00) stop_last_new = STOP15_LAST;
        else                  stop_last_new = STOP2_LAST;
    end

    // Frame sequencer: state, tick count, data shift and format capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= S_IDLE;
            cnt       <= '0;
            sh        <= '0;
            idx       <= '0;
            last_idx  <= '0;
            par_on    <= 1'b0;
            par_val   <= 1'b0;
            stop_last <= '0;
        end else if (load) begin
            state     <= S_START;
            cnt       <= '0;
            sh        <= hold_data;
            idx       <= '0;
            last_idx  <= IW'(4) + IW'(wls);
            par_on    <= par_en;
            par_val   <= parity_bit(hold_data, wls, par_stick, par_even);
            stop_last <= stop_last_new;
        end else if (tick_en) begin
            case (state)
                S_IDLE: cnt <= '0;
                S_START: begin
                    cnt <= bit_done ? '0 : cnt + 1'b1;
                    if (bit_done) state <= S_DATA;
                end
                S_DATA: begin
                    cnt <= bit_done ? '0 : cnt + 1'b1;
                    if (bit_done) begin
                        sh <= sh >> 1;
                        if (idx == last_idx) state <= par_on ? S_PAR : S_STOP;
                        else                 idx <= idx + 1'b1;
                    end
                end
                S_PAR: begin
                    cnt <= bit_done ? '0 : cnt + 1'b1;
                    if (bit_done) state <= S_STOP;
                end
                S_STOP: begin
                    cnt <= stop_done ? '0 : cnt + 1'b1;
                    if (stop_done) state <= S_IDLE;
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    // Line level selected by the current frame position
    always_comb begin
        case (state)
            S_START: line = 1'b0;
            S_DATA:  line = sh[0];
            S_PAR:   line = par_val;
            default: line = 1'b1;
        endcase
    end

endmodule

// File: rtl/uart_tx_framer.sv
// Module: transmit framer top. Joins the format register, holding buffer
// and serializer; gates the baud tick and applies the break override.
// Assumes baud_tick is synchronous to clk and at most one cycle wide.
module uart_tx_framer
    import uart_tx_pkg::*;
#(
    parameter int DW  = DATA_W,
    parameter int TPB = OVS
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          lcr_wr,
    input  logic [7:0]    lcr_wdata,
    output logic [7:0]    lcr_rdata,
    input  logic          thr_wr,
    input  logic [DW-1:0] thr_wdata,
    input  logic          baud_tick,
    output logic          tx_out,
    output logic          thr_empty
);

    fmt_t          fmt;
    logic [DW-1:0] hold_data;
    logic          hold_full;
    logic          load;
    logic          line;
    logic          tick_en;

    uart_tx_ctrl_reg #(.W(8)) u_fmt (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (lcr_wr),
        .wdata (lcr_wdata),
        .q     (lcr_rdata)
    );

    // View the raw register as named fields
    always_comb fmt = fmt_t'(lcr_rdata);

    // Baud tick passes only when the generator is enabled
    always_comb tick_en = baud_tick && fmt.brg_en;

    uart_tx_holding #(.DW(DW)) u_hold (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (thr_wr),
        .wdata (thr_wdata),
        .load  (load),
        .data  (hold_data),
        .full  (hold_full)
    );

    uart_tx_shifter #(.DW(DW), .TPB(TPB)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_en   (tick_en),
        .hold_full (hold_full),
        .hold_data (hold_data),
        .par_en    (fmt.par_en),
        .par_even  (fmt.even),
        .par_stick (fmt.stick),
        .stop_sel  (fmt.stop_sel),
        .wls       (fmt.wls),
        .load      (load),
        .line      (line)
    );

    // Break forces the line low; otherwise the serializer drives it
    always_comb begin
        tx_out    = fmt.brk ? 1'b0 : line;
        thr_empty = ~hold_full;
    end

endmodule

// File: rtl/uart_tx_framer_chk.sv
// Module: protocol checker for the transmit framer, attached by bind.
module uart_tx_framer_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       lcr_wr,
    input logic [7:0] lcr_wdata,
    input logic [7:0] lcr_rdata,
    input logic       thr_wr,
    input logic       baud_tick,
    input logic       tx_out,
    input logic       thr_empty
);

    AST_FMT_READBACK: assert property (@(posedge clk) disable iff (!rst_n)
        lcr_wr |=> (lcr_rdata == $past(lcr_wdata))); // R2

    AST_WRITE_FILLS: assert property (@(posedge clk) disable iff (!rst_n)
        thr_wr |=> !thr_empty); // R6

    AST_BREAK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        lcr_rdata[6] |-> !tx_out); // R7

    AST_GATED_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        (!lcr_rdata[7] && !lcr_wr) |=> $stable(tx_out)); // R8

    AST_LOAD_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(thr_empty) |-> $past(lcr_rdata[7] && baud_tick)); // R8

endmodule

bind uart_tx_framer uart_tx_framer_chk chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .lcr_wr    (lcr_wr),
    .lcr_wdata (lcr_wdata),
    .lcr_rdata (lcr_rdata),
    .thr_wr    (thr_wr),
    .baud_tick (baud_tick),
    .tx_out    (tx_out),
    .thr_empty (thr_empty)
);

// File: tb/uart_tx_framer_tb_top.sv
// Bench: directed scenarios for the transmit framer. Inputs change on
// falling edges; outputs are sampled on falling edges.
module uart_tx_framer_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       lcr_wr = 1'b0;
    logic [7:0] lcr_wdata = '0;
    logic [7:0] lcr_rdata;
    logic       thr_wr = 1'b0;
    logic [7:0] thr_wdata = '0;
    logic       baud_tick = 1'b1;
    logic       tx_out;
    logic       thr_empty;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    uart_tx_framer dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .lcr_wr    (lcr_wr),
        .lcr_wdata (lcr_wdata),
        .lcr_rdata (lcr_rdata),
        .thr_wr    (thr_wr),
        .thr_wdata (thr_wdata),
        .baud_tick (baud_tick),
        .tx_out    (tx_out),
        .thr_empty (thr_empty)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic write_lcr(input logic [7:0] v);
        @(negedge clk); lcr_wr = 1'b1; lcr_wdata = v;
        @(negedge clk); lcr_wr = 1'b0;
    endtask

    task automatic write_thr(input logic [7:0] v);
        @(negedge clk); thr_wr = 1'b1; thr_wdata = v;
        @(negedge clk); thr_wr = 1'b0;
    endtask

    // Wait on falling edges until the line goes low; returns that cycle
    task automatic wait_fall(output int t);
        int guard = 0;
        while (tx_out !== 1'b0 && guard < 3000) begin
            @(negedge clk); guard++;
        end
        check(guard < 3000, "R3", "start edge timeout", guard, 0);
        t = cyc;
    endtask

    function automatic int frame_cycles(input logic [7:0] f);
        int nb = 5 + int'(f[1:0]);
        int st = f[2] ? ((f[1:0] == 2'b00) ? 24 : 32) : 16;
        return 16 * (1 + nb + int'(f[3])) + st;
    endfunction

    // Sample each bit centre from a start edge at the current negedge
    task automatic decode(input logic [7:0] f, input logic [7:0] d, input string req);
        logic exp_bits[12];
        int   n = 0;
        int   nb = 5 + int'(f[1:0]);
        logic ones = 1'b0;
        exp_bits[n++] = 1'b0;
        for (int i = 0; i < nb; i++) begin
            exp_bits[n++] = d[i];
            ones ^= d[i];
        end
        if (f[3]) begin
            if (f[5]) exp_bits[n++] = ~f[4];
            else      exp_bits[n++] = f[4] ? ones : ~ones;
        end
        exp_bits[n++] = 1'b1;
        for (int k = 0; k < n; k++) begin
            repeat ((k == 0) ? 8 : 16) @(negedge clk);
            check(tx_out === exp_bits[k], req, $sformatf("bit %0d of 0x%0h", k, d),
                  int'(tx_out), int'(exp_bits[k]));
        end
    endtask

    task automatic t_reset;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(tx_out === 1'b1, "R1", "idle line", int'(tx_out), 1);
        check(thr_empty === 1'b1, "R1", "empty flag", int'(thr_empty), 1);
        check(lcr_rdata === 8'h00, "R1", "format reg", int'(lcr_rdata), 0);
    endtask

    task automatic t_readback;
        write_lcr(8'h3D);
        check(lcr_rdata === 8'h3D, "R2", "readback", int'(lcr_rdata), 'h3D);
        write_lcr(8'hC2);
        check(lcr_rdata === 8'hC2, "R2", "readback", int'(lcr_rdata), 'hC2);
        write_lcr(8'h00);
    endtask

    // Two queued bytes: checks both frames and the start-to-start spacing
    task automatic run_pair(input logic [7:0] f, input logic [7:0] a,
                            input logic [7:0] b, input string req);
        int t0, t1;
        write_lcr(f);
        write_thr(a);
        fork
            begin
                int g = 0;
                while (thr_empty !== 1'b1 && g < 100) begin @(negedge clk); g++; end
                check(g < 100, "R6", "flag rise on load", g, 0);
                write_thr(b);
            end
            begin
                wait_fall(t0);
                decode(f, a, req);
            end
        join
        wait_fall(t1);
        check(t1 - t0 == frame_cycles(f), "R5", $sformatf("frame spacing fmt 0x%0h", f),
              t1 - t0, frame_cycles(f));
        decode(f, b, req);
        repeat (40) @(negedge clk);
    endtask

    task automatic t_break;
        write_lcr(8'hC3);
        check(tx_out === 1'b0, "R7", "break low", int'(tx_out), 0);
        repeat (5) @(negedge clk);
        check(tx_out === 1'b0, "R7", "break held", int'(tx_out), 0);
        write_lcr(8'h83);
        check(tx_out === 1'b1, "R7", "break released", int'(tx_out), 1);
    endtask

    task automatic t_gate;
        int t0;
        write_lcr(8'h03);
        write_thr(8'h96);
        repeat (60) @(negedge clk);
        check(thr_empty === 1'b0, "R8", "byte not taken", int'(thr_empty), 0);
        check(tx_out === 1'b1, "R8", "line held idle", int'(tx_out), 1);
        write_lcr(8'h83);
        wait_fall(t0);
        decode(8'h83, 8'h96, "R8");
        repeat (20) @(negedge clk);
    endtask

    task automatic t_latch;
        int t0;
        write_lcr(8'h83);
        write_thr(8'hC9);
        wait_fall(t0);
        fork
            decode(8'h83, 8'hC9, "R9");
            begin
                repeat (40) @(negedge clk);
                lcr_wr = 1'b1; lcr_wdata = 8'h8C;
                @(negedge clk);
                lcr_wr = 1'b0;
            end
        join
        repeat (20) @(negedge clk);
        write_thr(8'h15);
        wait_fall(t0);
        decode(8'h8C, 8'h15, "R9");
        repeat (40) @(negedge clk);
    endtask

    task automatic t_collide;
        int t0, t1;
        write_lcr(8'h83);
        @(negedge clk); thr_wr = 1'b1; thr_wdata = 8'h4E;
        @(negedge clk); thr_wdata = 8'hB1;
        @(negedge clk); thr_wr = 1'b0;
        check(thr_empty === 1'b0, "R10", "flag after collision", int'(thr_empty), 0);
        wait_fall(t0);
        decode(8'h83, 8'h4E, "R10");
        wait_fall(t1);
        check(t1 - t0 == frame_cycles(8'h83), "R10", "second frame spacing",
              t1 - t0, frame_cycles(8'h83));
        decode(8'h83, 8'hB1, "R10");
        repeat (40) @(negedge clk);
        check(thr_empty === 1'b1, "R6", "flag after drain", int'(thr_empty), 1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        t_readback();
        run_pair(8'h83, 8'hA5, 8'h5A, "R3");
        run_pair(8'h84, 8'h1B, 8'h04, "R5");
        run_pair(8'h9A, 8'h35, 8'h6E, "R4");
        run_pair(8'h8D, 8'h2C, 8'h13, "R4");
        run_pair(8'hAB, 8'hF0, 8'h0F, "R4");
        run_pair(8'hBB, 8'h81, 8'h7E, "R4");
        run_pair(8'h81, 8'h2A, 8'h15, "R3");
        t_break();
        t_gate();
        t_latch();
        t_collide();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule